// File: doc/BRIEF.md
# Segment/Page Address Translator

This block maps 32-bit virtual addresses to physical addresses through two lookups held in on-chip RAM. The first is a segment map, indexed by the current context and the segment number, which returns a page-group number. The second is a page table, indexed by context, group and page index, which returns a page descriptor. The descriptor carries a valid flag, write and supervisor permissions, a two-bit address-space type, accessed and modified flags and a 16-bit frame number. The block checks the access against the descriptor and either returns a physical address with a write-permission flag, or returns a fault code. On a permitted access it writes the descriptor back with the accessed flag set, and with the modified flag set as well on a write.

Software fills both tables through a simple host port. It reads back the fault address and fault status registers through the same port. The two registers hold the most recent faulting access. One translation is in flight at a time. Each translation runs a fixed three-stage sequence: segment read, descriptor read, then check with write-back.

Top module: `segpage_mmu`

## Requirements
- R1: After reset, resp_valid is 0 and req_ready and host_ready are 1. Reading the fault address register (host_sel 2) and the fault status register (host_sel 3) returns 0.
- R2: The segment-map index is {cur_ctx, va[18+SEG_BITS-1:18]}, and segment-number bits above SEG_BITS are ignored. The stored group number is GRP_BITS wide and reads back zero-extended through host_sel 0. The host address for host_sel 0 is the segment-map index.
- R3: For a permitted access, resp_pa = {4'b0, pfn, va[11:0]}. When the space field (descriptor bits 27:26) equals 1, this value is ORed with 32'hF000_0000. Space values 0, 2 and 3 add nothing.
- R4: The descriptor layout is: bit 31 valid, 30 writable, 29 supervisor-only, 28 cacheable, 27:26 space, 25 accessed, 24 modified, 15:0 frame number. Host access uses host_sel 1 with the address {ctx, group, page}. Bits 23:16 are not stored and always read back as 0.
- R5: A descriptor with the valid bit clear gives resp_fault 1, resp_pa 0 and resp_wr_ok 0, and the descriptor is left unchanged.
- R6: A valid descriptor with the supervisor-only bit set, accessed with req_user = 1, gives resp_fault 2 and leaves the descriptor unchanged.
- R7: A write (req_wr = 1) to a descriptor whose writable bit is clear gives resp_fault 3 and leaves the descriptor unchanged. When several conditions apply, the priority is invalid (1), then supervisor (2), then write (3).
- R8: A permitted access gives resp_fault 0 and stores the descriptor back with the accessed bit set, and with the modified bit also set when req_wr = 1. resp_wr_ok equals writable AND modified, taken from the updated descriptor.
- R9: On any fault, the fault address register takes the virtual address. The fault status register takes {29'b0, req_wr, fault code}. Both hold their values through later successful translations.
- R10: A request accepted at a clock edge gives a one-cycle resp_valid pulse after the third edge that follows. req_ready and host_ready are low for the two cycles in between. host_req has priority over req_valid when both are present while the block is idle. Host read data is valid, with host_rvalid, in the cycle after the host access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 segment map, 1 descriptor table, 2 fault address, 3 fault status |
| host_addr | input | max(CTX_BITS+SEG_BITS, CTX_BITS+GRP_BITS+6) | Table index |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Host access accepted when high |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted when high |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| cur_ctx | input | CTX_BITS | Context number for this request |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 2 | 0 none, 1 invalid, 2 supervisor, 3 write-protect |
| resp_pa | output | 32 | Physical address (0 on fault) |
| resp_wr_ok | output | 1 | Page may be written without a further update |

## Verification
The assertions assume that the host does not touch the tables while a translation is in flight; the block enforces this itself by holding host_ready low. They also assume that every descriptor read by a translation was written first, since RAM contents are undefined after reset. The stimulus fills every segment-map and descriptor entry through the host port before it issues any translation. It then keeps a model of both tables in step with each host write and each expected write-back. The stimulus varies descriptor contents, contexts, upper segment bits, access type and privilege at random. Directed cases cover the fault priority chain, the space type and the reserved bits.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_SUPER   = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        HSEL_SEG  = 2'd0,
        HSEL_PTE  = 2'd1,
        HSEL_FVA  = 2'd2,
        HSEL_FST  = 2'd3
    } hsel_e;

    typedef struct packed {
        logic        valid;
        logic        wr;
        logic        sup;
        logic        cache;
        logic [1:0]  space;
        logic        acc;
        logic        mod;
        logic [7:0]  rsvd;
        logic [15:0] pfn;
    } pte_t;

    localparam int          PTE_STORE_W = 24;
    localparam logic [1:0]  SPACE_IO    = 2'd1;
    localparam logic [31:0] IO_BASE     = 32'hF000_0000;

    typedef struct packed {
        fault_e      code;
        logic [31:0] pa;
        logic        wr_ok;
        logic        wb;
        pte_t        upd;
    } chk_t;

    function automatic logic [PTE_STORE_W-1:0] pte_pack(pte_t p);
        return {p.valid, p.wr, p.sup, p.cache, p.space, p.acc, p.mod, p.pfn};
    endfunction

    function automatic pte_t pte_unpack(logic [PTE_STORE_W-1:0] s);
        pte_t p;
        p = '{valid: s[23], wr: s[22], sup: s[21], cache: s[20],
              space: s[19:18], acc: s[17], mod: s[16], rsvd: 8'h00,
              pfn: s[15:0]};
        return p;
    endfunction

endpackage

// File: rtl/mmu_ram.sv
module mmu_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mmu_check.sv
module mmu_check
    import mmu_pkg::*;
(
    input  pte_t        pte,
    input  logic        acc_wr,
    input  logic        acc_user,
    input  logic [11:0] offset,
    output chk_t        res
);
    logic unused_cache;
    assign unused_cache = pte.cache;

    always_comb begin
        res       = '0;
        res.upd   = pte;
        if (!pte.valid)                res.code = FLT_INVALID;
        else if (acc_user && pte.sup)  res.code = FLT_SUPER;
        else if (acc_wr && !pte.wr)    res.code = FLT_WPROT;
        else                           res.code = FLT_NONE;

        if (res.code == FLT_NONE) begin
            res.wb      = 1'b1;
            res.upd.acc = 1'b1;
            if (acc_wr) res.upd.mod = 1'b1;
            res.pa      = {4'b0000, pte.pfn, offset};
            if (pte.space == SPACE_IO) res.pa = res.pa | IO_BASE;
            res.wr_ok   = res.upd.wr && res.upd.mod;
        end
    end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
    import mmu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap,
    input  logic [31:0] va,
    input  fault_e      code,
    input  logic        acc_wr,
    output logic [31:0] fault_va,
    output logic [31:0] fault_stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fault_va   <= '0;
            fault_stat <= '0;
        end else if (cap) begin
            fault_va   <= va;
            fault_stat <= {29'd0, acc_wr, code};
        end
    end
endmodule

// File: rtl/segpage_mmu.sv
module segpage_mmu
    import mmu_pkg::*;
#(
    parameter int CTX_BITS = 3,
    parameter int SEG_BITS = 4,
    parameter int GRP_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_wr,
    input  logic [1:0]          host_sel,
    input  logic [((CTX_BITS+SEG_BITS) > (CTX_BITS+GRP_BITS+6) ?
                   (CTX_BITS+SEG_BITS) : (CTX_BITS+GRP_BITS+6))-1:0] host_addr,
    input  logic [31:0]         host_wdata,
    output logic                host_ready,
    output logic                host_rvalid,
    output logic [31:0]         host_rdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [31:0]         req_va,
    input  logic                req_wr,
    input  logic                req_user,
    input  logic [CTX_BITS-1:0] cur_ctx,
    output logic                resp_valid,
    output logic [1:0]          resp_fault,
    output logic [31:0]         resp_pa,
    output logic                resp_wr_ok
);
    localparam int SEG_IDX_W = CTX_BITS + SEG_BITS;
    localparam int PTE_IDX_W = CTX_BITS + GRP_BITS + 6;
    localparam int SEG_LSB   = 18;

    // stage valids and registers
    logic                 s1_v, s2_v;
    logic [31:0]          s1_va, s2_va;
    logic                 s1_wr, s2_wr, s1_user, s2_user;
    logic [CTX_BITS-1:0]  s1_ctx;
    logic [PTE_IDX_W-1:0] s2_pidx;

    logic idle, host_go, acc;
    assign idle       = !s1_v && !s2_v;
    assign host_ready = idle;
    assign host_go    = host_req && idle;
    assign req_ready  = idle && !host_req;
    assign acc        = req_valid && req_ready;

    logic unused_host;
    assign unused_host = ^host_wdata[23:16];

    // segment map
    logic                 seg_we, seg_re;
    logic [SEG_IDX_W-1:0] seg_raddr;
    logic [GRP_BITS-1:0]  seg_rdata;

    assign seg_we    = host_go && host_wr && (host_sel == HSEL_SEG);
    assign seg_re    = acc || (host_go && !host_wr && (host_sel == HSEL_SEG));
    assign seg_raddr = host_go ? host_addr[SEG_IDX_W-1:0]
                               : {cur_ctx, req_va[SEG_LSB +: SEG_BITS]};

    mmu_ram #(.DW(GRP_BITS), .AW(SEG_IDX_W)) seg_ram_i (
        .clk   (clk),
        .we    (seg_we),
        .waddr (host_addr[SEG_IDX_W-1:0]),
        .wdata (host_wdata[GRP_BITS-1:0]),
        .re    (seg_re),
        .raddr (seg_raddr),
        .rdata (seg_rdata)
    );

    // descriptor table
    chk_t                   chk;
    logic                   pte_we, pte_re;
    logic [PTE_IDX_W-1:0]   pte_raddr, pte_waddr;
    logic [PTE_STORE_W-1:0] pte_wdata, pte_rdata;
    pte_t                   pte_cur;

    assign pte_re    = s1_v || (host_go && !host_wr && (host_sel == HSEL_PTE));
    assign pte_raddr = host_go ? host_addr[PTE_IDX_W-1:0]
                               : {s1_ctx, seg_rdata, s1_va[17:12]};
    assign pte_we    = (s2_v && chk.wb) ||
                       (host_go && host_wr && (host_sel == HSEL_PTE));
    assign pte_waddr = s2_v ? s2_pidx : host_addr[PTE_IDX_W-1:0];
    assign pte_wdata = s2_v ? pte_pack(chk.upd) : pte_pack(pte_t'(host_wdata));
    assign pte_cur   = pte_unpack(pte_rdata);

    mmu_ram #(.DW(PTE_STORE_W), .AW(PTE_IDX_W)) pte_ram_i (
        .clk   (clk),
        .we    (pte_we),
        .waddr (pte_waddr),
        .wdata (pte_wdata),
        .re    (pte_re),
        .raddr (pte_raddr),
        .rdata (pte_rdata)
    );

    mmu_check check_i (
        .pte      (pte_cur),
        .acc_wr   (s2_wr),
        .acc_user (s2_user),
        .offset   (s2_va[11:0]),
        .res      (chk)
    );

    logic [31:0] fault_va, fault_stat;

    mmu_fault_regs fregs_i (
        .clk        (clk),
        .rst        (rst),
        .cap        (s2_v && (chk.code != FLT_NONE)),
        .va         (s2_va),
        .code       (chk.code),
        .acc_wr     (s2_wr),
        .fault_va   (fault_va),
        .fault_stat (fault_stat)
    );

    // pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v       <= 1'b0;
            s2_v       <= 1'b0;
            resp_valid <= 1'b0;
            resp_fault <= FLT_NONE;
            resp_pa    <= '0;
            resp_wr_ok <= 1'b0;
        end else begin
            s1_v       <= acc;
            s2_v       <= s1_v;
            resp_valid <= s2_v;
            if (s2_v) begin
                resp_fault <= chk.code;
                resp_pa    <= chk.pa;
                resp_wr_ok <= chk.wr_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc) begin
            s1_va   <= req_va;
            s1_wr   <= req_wr;
            s1_user <= req_user;
            s1_ctx  <= cur_ctx;
        end
        if (s1_v) begin
            s2_va   <= s1_va;
            s2_wr   <= s1_wr;
            s2_user <= s1_user;
            s2_pidx <= pte_raddr;
        end
    end

    // host read return
    logic  hr_v;
    hsel_e hr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            hr_v   <= 1'b0;
            hr_sel <= HSEL_SEG;
        end else begin
            hr_v   <= host_go && !host_wr;
            hr_sel <= hsel_e'(host_sel);
        end
    end

    assign host_rvalid = hr_v;

    always_comb begin
        host_rdata = '0;
        if (hr_v) begin
            case (hr_sel)
                HSEL_SEG: host_rdata = {{(32-GRP_BITS){1'b0}}, seg_rdata};
                HSEL_PTE: host_rdata = pte_cur;
                HSEL_FVA: host_rdata = fault_va;
                default:  host_rdata = fault_stat;
            endcase
        end
    end

    // assertions
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        acc |-> ##3 resp_valid);

    a_r10_busy: assert property (@(posedge clk) disable iff (rst)
        acc |=> (!req_ready && !host_ready) ##1 (!req_ready && !host_ready));

    a_r9_fault_hold: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == FLT_NONE) |-> ($stable(fault_va) && $stable(fault_stat)));

    a_r8_wb_accessed: assert property (@(posedge clk) disable iff (rst)
        (s2_v && pte_we) |-> pte_unpack(pte_wdata).acc);

    a_r3_offset: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == FLT_NONE) |-> (resp_pa[11:0] == $past(s2_va[11:0])));

    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && hr_sel == HSEL_PTE) |-> (host_rdata[23:16] == 8'h00));
endmodule

// File: tb/segpage_mmu_tb_top.sv
module segpage_mmu_tb_top;
    localparam int CB = 3, SB = 4, GB = 2;
    localparam int SEGN = 1 << (CB + SB);
    localparam int PTEN = 1 << (CB + GB + 6);
    localparam int HAW  = (CB + GB + 6);

    logic clk = 1'b0, rst = 1'b1;
    always #2 clk = ~clk;

    logic host_req = 0, host_wr = 0;
    logic [1:0] host_sel = 0;
    logic [HAW-1:0] host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic host_ready, host_rvalid;
    logic [31:0] host_rdata;
    logic req_valid = 0, req_ready, req_wr = 0, req_user = 0;
    logic [31:0] req_va = 0;
    logic [CB-1:0] cur_ctx = 0;
    logic resp_valid, resp_wr_ok;
    logic [1:0] resp_fault;
    logic [31:0] resp_pa;

    segpage_mmu #(.CTX_BITS(CB), .SEG_BITS(SB), .GRP_BITS(GB)) dut_i (.*);

    int n_vec = 0, n_bad = 0;
    logic [GB-1:0] seg_m [SEGN];
    logic [31:0]   pte_m [PTEN];
    logic [1:0]  r_code;
    logic [31:0] r_pa, rd;
    logic        r_wrok;
    logic [31:0] lf_va, lf_st;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    task automatic hwrite(logic [1:0] sel, int addr, logic [31:0] d);
        @(negedge clk);
        host_req = 1; host_wr = 1; host_sel = sel;
        host_addr = HAW'(addr); host_wdata = d;
        @(negedge clk);
        host_req = 0; host_wr = 0;
        if (sel == 2'd0) seg_m[addr] = d[GB-1:0];
        if (sel == 2'd1) pte_m[addr] = d & 32'hFF00_FFFF;
    endtask

    task automatic hread(logic [1:0] sel, int addr, output logic [31:0] d);
        @(negedge clk);
        host_req = 1; host_wr = 0; host_sel = sel; host_addr = HAW'(addr);
        @(negedge clk);
        host_req = 0;
        if (!host_rvalid) chk("R10 host_rvalid", 0, 1);
        d = host_rdata;
    endtask

    function automatic int pidx(int ctx, int grp, int pg);
        return (ctx << (GB + 6)) | (grp << 6) | pg;
    endfunction

    // independent expected model; updates model table on success
    task automatic expect_x(int ctx, logic [31:0] va, logic w, logic u,
                            output logic [1:0] c, output logic [31:0] pa,
                            output logic ok, output int pi);
        int si = (ctx << SB) | int'(va[18 +: SB]);
        logic [31:0] p;
        pi = pidx(ctx, int'(seg_m[si]), int'(va[17:12]));
        p  = pte_m[pi];
        pa = 0; ok = 0;
        if (!p[31])          c = 2'd1;
        else if (u && p[29]) c = 2'd2;
        else if (w && !p[30]) c = 2'd3;
        else begin
            c = 2'd0;
            p[25] = 1'b1;
            if (w) p[24] = 1'b1;
            pte_m[pi] = p;
            pa = {4'h0, p[15:0], va[11:0]};
            if (p[27:26] == 2'd1) pa = pa | 32'hF000_0000;
            ok = p[30] & p[24];
        end
        if (c != 0) begin lf_va = va; lf_st = {29'd0, w, c}; end
    endtask

    task automatic xlate(int ctx, logic [31:0] va, logic w, logic u);
        @(negedge clk);
        if (!req_ready) chk("R10 ready idle", 0, 1);
        req_valid = 1; req_va = va; req_wr = w; req_user = u; cur_ctx = CB'(ctx);
        @(negedge clk);
        req_valid = 0;
        chk("R10 ready low", {31'd0, req_ready}, 0);
        @(negedge clk);
        chk("R10 no early resp", {31'd0, resp_valid}, 0);
        @(negedge clk);
        chk("R10 resp pulse", {31'd0, resp_valid}, 1);
        r_code = resp_fault; r_pa = resp_pa; r_wrok = resp_wr_ok;
    endtask

    task automatic run_check(string tag, int ctx, logic [31:0] va, logic w, logic u);
        logic [1:0] c; logic [31:0] pa; logic ok; int pi;
        expect_x(ctx, va, w, u, c, pa, ok, pi);
        xlate(ctx, va, w, u);
        chk({tag, " code"}, {30'd0, r_code}, {30'd0, c});
        chk({tag, " pa"}, r_pa, pa);
        chk({tag, " wr_ok"}, {31'd0, r_wrok}, {31'd0, ok});
    endtask

    function automatic logic [31:0] rnd_pte();
        logic [31:0] p = $urandom;
        p[31] = ($urandom % 4) != 0;
        p[29] = ($urandom % 4) == 0;
        return p;
    endfunction

    initial begin
        logic [31:0] va;
        int pi;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 resp_valid", {31'd0, resp_valid}, 0);
        chk("R1 req_ready", {31'd0, req_ready}, 1);
        chk("R1 host_ready", {31'd0, host_ready}, 1);
        hread(2'd2, 0, rd); chk("R1 fault va", rd, 0);
        hread(2'd3, 0, rd); chk("R1 fault status", rd, 0);

        // fill tables
        for (int i = 0; i < SEGN; i++) hwrite(2'd0, i, $urandom);
        for (int i = 0; i < PTEN; i++) hwrite(2'd1, i, rnd_pte());

        // R4 reserved bits and layout
        hwrite(2'd1, 5, 32'hFFFF_FFFF);
        hread(2'd1, 5, rd); chk("R4 rsvd zero", rd, 32'hFF00_FFFF);
        // R2 group width
        hwrite(2'd0, 9, 32'hFFFF_FFFF);
        hread(2'd0, 9, rd); chk("R2 group zero-ext", rd, (1 << GB) - 1);

        // R3 space types: ctx 1, seg 2 -> group 1, page 3
        hwrite(2'd0, (1 << SB) | 2, 32'd1);
        pi = pidx(1, 1, 3);
        hwrite(2'd1, pi, 32'h8400_1234);   // valid, space 1
        run_check("R3 io space", 1, 32'h0008_3ABC, 0, 0);
        chk("R3 io base", r_pa, 32'hF123_4ABC);
        hwrite(2'd1, pi, 32'h8800_1234);   // space 2
        run_check("R3 space2", 1, 32'h0008_3ABC, 0, 0);
        chk("R3 space2 pa", r_pa, 32'h0123_4ABC);
        // R2 upper segment bits ignored
        run_check("R2 alias", 1, 32'h3C08_3ABC, 0, 1);

        // R7 priority chain, R5/R6 unchanged
        hwrite(2'd1, pi, 32'h2000_0077);   // invalid, sup, not writable
        run_check("R5 invalid first", 1, 32'h0008_3001, 1, 1);
        chk("R7 prio invalid", {30'd0, r_code}, 1);
        hread(2'd1, pi, rd); chk("R5 pte unchanged", rd, 32'h2000_0077);
        hwrite(2'd1, pi, 32'hA000_0077);   // valid, sup, not writable
        run_check("R6 super", 1, 32'h0008_3002, 1, 1);
        chk("R7 prio super", {30'd0, r_code}, 2);
        hread(2'd1, pi, rd); chk("R6 pte unchanged", rd, 32'hA000_0077);
        run_check("R7 wprot", 1, 32'h0008_3003, 1, 0);
        chk("R7 prio write", {30'd0, r_code}, 3);
        hread(2'd1, pi, rd); chk("R7 pte unchanged", rd, 32'hA000_0077);
        hread(2'd2, 0, rd); chk("R9 fault va", rd, 32'h0008_3003);
        hread(2'd3, 0, rd); chk("R9 fault status", rd, 32'h0000_0007);

        // R8 accessed / modified
        hwrite(2'd1, pi, 32'hC000_0042);   // valid writable
        run_check("R8 read", 1, 32'h0008_3010, 0, 1);
        hread(2'd1, pi, rd); chk("R8 accessed only", rd, 32'hC200_0042);
        chk("R8 wr_ok clean", {31'd0, r_wrok}, 0);
        run_check("R8 write", 1, 32'h0008_3010, 1, 1);
        hread(2'd1, pi, rd); chk("R8 modified", rd, 32'hC300_0042);
        // R9 hold after success
        hread(2'd2, 0, rd); chk("R9 hold va", rd, 32'h0008_3003);

        // R10 host priority
        @(negedge clk);
        host_req = 1; host_wr = 0; host_sel = 2'd3; req_valid = 1;
        #1;
        chk("R10 host prio req_ready", {31'd0, req_ready}, 0);
        chk("R10 host prio host_ready", {31'd0, host_ready}, 1);
        @(negedge clk);
        host_req = 0; req_valid = 0;
        chk("R10 host rvalid", {31'd0, host_rvalid}, 1);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int ctx = int'($urandom % (1 << CB));
            va = $urandom;
            run_check("R8 rand", ctx, va, 1'($urandom), 1'($urandom));
            if (n % 8 == 0) begin
                int p = int'($urandom % PTEN);
                hread(2'd1, p, rd); chk("R8 table", rd, pte_m[p]);
                hread(2'd2, 0, rd); chk("R9 rand va", rd, lf_va);
                hread(2'd3, 0, rd); chk("R9 rand status", rd, lf_st);
            end
        end
        summary();
    end
endmodule